// File: doc/BRIEF.md
# PLL Divider Parameter Search Engine

This block chooses divider settings for a programmable clock synthesiser whose output is `ref * M / (N1 * 2^N2)`. A controller gives it a target frequency and the allowed window of the oscillator frequency `ref * M / N1`, all as 16.16 fixed-point multiples of the reference. It also gives the smallest post-divider exponent that may be used. One start pulse launches a search over every permitted (N2, N1) pair. The engine evaluates one pair per clock, rounds M for each pair, discards pairs that break the M range or the oscillator window, and keeps the pair with the smallest output error.

When the search ends, the engine raises `done` for one cycle. At the same time it presents the winning dividers, already packed into the two byte-wide register codes that the synthesiser expects. A target that no permitted setting can reach is turned away at once with `found` low.

Top module: `pll_divider_search`

## Requirements
- R1: A start accepted with `target*8 < vco_lo` or `target*2^n2_floor > vco_hi` (exact integer compare) is rejected. The accepting edge itself sets `done`, with `found`=0, `m_code`=0x7D and `n_code`=0x50.
- R2: Candidates are visited with N2 as the outer loop, from `n2_floor` up to 3, and N1 as the inner loop, from 3 up to 33. A later candidate replaces the best only when its error is strictly smaller, so the first of equal candidates is kept.
- R3: For each candidate, M = floor((target*N1*2^N2 + 2^15) / 2^16), which rounds half up. A candidate with M outside 3..129 is skipped.
- R4: A candidate is considered only when M*2^16 lies within [vco_lo*N1, vco_hi*N1], bounds included.
- R5: Errors are compared exactly as |target*N1*2^N2 − M*2^16| / (N1*2^N2). The initial best error equals the target value.
- R6: A search in which no candidate qualifies still ends with `found`=1 and returns the default M=127, N1=18, N2=2, encoded as `m_code`=0x7D and `n_code`=0x50.
- R7: Result encoding: `m_code` = M−2; `n_code` bits [4:0] = N1−2, bits [6:5] = N2, bit 7 = 0.
- R8: For an accepted search, `done` is set by the clock edge that comes (4−n2_floor)×31 edges after the accepting edge.
- R9: While a search runs, `start` is ignored. The target, window and floor used by a search are those present at the accepting edge.
- R10: `done` lasts exactly one cycle. `found`, `m_code` and `n_code` change only in a cycle where `done` is set, and they hold their values otherwise.
- R11: After reset, `done`, `found`, `m_code` and `n_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, taken only when idle |
| target_ratio | input | 24 | Target / reference, 16.16 fixed point |
| vco_lo | input | 24 | Oscillator window lower bound / reference, 16.16 |
| vco_hi | input | 24 | Oscillator window upper bound / reference, 16.16 |
| n2_floor | input | 2 | Smallest permitted N2 |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | 1 when the search ran, 0 when the target was rejected |
| m_code | output | 8 | Encoded M divider |
| n_code | output | 8 | Encoded N1/N2 byte |

## Verification
The bench builds the engine with its default parameters: 16 fractional bits, 8 integer bits, N1 from 3 to 33 and N2 up to 3. With these settings every floor value from 0 to 3, and hence every search length from 31 to 124 candidates, can be reached. Random targets and windows exercise the rounding, window and tie rules against an exact integer model. Directed cases place the target exactly on and one step past each rejection bound, and use a window that no rational M/N1 can meet, which forces the default result. One run pulses `start` mid-search with different operands to show that the pulse has no effect.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

   typedef enum logic {
      WALK_IDLE = 1'b0,
      WALK_RUN  = 1'b1
   } walk_state_e;

endpackage

// File: rtl/pll_cand_eval.sv
// Combinational scoring of one (N1, N2) candidate.
module pll_cand_eval #(
   parameter int FRAC_W = 16,
   parameter int TW     = 24,
   parameter int N1W    = 6,
   parameter int N2W    = 2,
   parameter int KW     = 9,
   parameter int PW     = 34,
   parameter int CODE_W = 8,
   parameter int M_LO   = 3,
   parameter int M_HI   = 129
) (
   input  logic [TW-1:0]     t,
   input  logic [TW-1:0]     lo,
   input  logic [TW-1:0]     hi,
   input  logic [N1W-1:0]    n1,
   input  logic [N2W-1:0]    n2,
   output logic              ok,
   output logic [PW-1:0]     err,
   output logic [KW-1:0]     k,
   output logic [CODE_W-1:0] m
);
   localparam int MW = PW - FRAC_W;

   logic [PW-1:0] prod, rnd, m_back, lo_n, hi_n;
   logic [MW-1:0] m_full;
   logic          m_in, vco_in;

   always_comb begin
      k      = KW'(n1) << n2;
      prod   = PW'(t) * PW'(k);
      rnd    = prod + (PW'(1) << (FRAC_W - 1));
      m_full = rnd[PW-1:FRAC_W];
      m_back = {m_full, {FRAC_W{1'b0}}};
      lo_n   = PW'(lo) * PW'(n1);
      hi_n   = PW'(hi) * PW'(n1);
      m_in   = (m_full >= MW'(M_LO)) && (m_full <= MW'(M_HI));
      vco_in = (m_back >= lo_n) && (m_back <= hi_n);
      ok     = m_in && vco_in;
      err    = (prod >= m_back) ? (prod - m_back) : (m_back - prod);
      m      = m_full[CODE_W-1:0];
   end
endmodule

// File: rtl/pll_best_keep.sv
// Holds the best candidate; strict less-than by cross-multiplied fractions.
module pll_best_keep #(
   parameter int TW     = 24,
   parameter int KW     = 9,
   parameter int PW     = 34,
   parameter int N1W    = 6,
   parameter int N2W    = 2,
   parameter int CODE_W = 8,
   parameter int DEF_M  = 127,
   parameter int DEF_N1 = 18,
   parameter int DEF_N2 = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              init,
   input  logic              step,
   input  logic [TW-1:0]     t,
   input  logic              cand_ok,
   input  logic [PW-1:0]     cand_err,
   input  logic [KW-1:0]     cand_k,
   input  logic [CODE_W-1:0] cand_m,
   input  logic [N1W-1:0]    cand_n1,
   input  logic [N2W-1:0]    cand_n2,
   output logic [CODE_W-1:0] nxt_m,
   output logic [N1W-1:0]    nxt_n1,
   output logic [N2W-1:0]    nxt_n2
);
   localparam int XW = PW + KW;

   logic [PW-1:0]     best_err;
   logic [KW-1:0]     best_k;
   logic [CODE_W-1:0] best_m;
   logic [N1W-1:0]    best_n1;
   logic [N2W-1:0]    best_n2;
   logic [XW-1:0]     lhs, rhs;
   logic              take;

   always_comb begin
      lhs    = XW'(cand_err) * XW'(best_k);
      rhs    = XW'(best_err) * XW'(cand_k);
      take   = step && cand_ok && (lhs < rhs);
      nxt_m  = take ? cand_m  : best_m;
      nxt_n1 = take ? cand_n1 : best_n1;
      nxt_n2 = take ? cand_n2 : best_n2;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         best_err <= '0;
         best_k   <= '0;
         best_m   <= '0;
         best_n1  <= '0;
         best_n2  <= '0;
      end else if (init) begin
         best_err <= PW'(t);
         best_k   <= KW'(1);
         best_m   <= CODE_W'(DEF_M);
         best_n1  <= N1W'(DEF_N1);
         best_n2  <= N2W'(DEF_N2);
      end else if (take) begin
         best_err <= cand_err;
         best_k   <= cand_k;
         best_m   <= cand_m;
         best_n1  <= cand_n1;
         best_n2  <= cand_n2;
      end
   end
endmodule

// File: rtl/pll_walk.sv
// Nested N2 / N1 walker, one candidate per cycle.
module pll_walk
   import pll_search_pkg::*;
#(
   parameter int N1W    = 6,
   parameter int N2W    = 2,
   parameter int N1_LO  = 3,
   parameter int N1_HI  = 33,
   parameter int N2_MAX = 3
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           launch,
   input  logic [N2W-1:0] floor_n2,
   output logic           busy,
   output logic           last,
   output logic [N1W-1:0] n1,
   output logic [N2W-1:0] n2
);
   walk_state_e state;

   assign busy = (state == WALK_RUN);
   assign last = busy && (n1 == N1W'(N1_HI)) && (n2 == N2W'(N2_MAX));

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= WALK_IDLE;
         n1    <= '0;
         n2    <= '0;
      end else if (state == WALK_IDLE) begin
         if (launch) begin
            state <= WALK_RUN;
            n1    <= N1W'(N1_LO);
            n2    <= floor_n2;
         end
      end else if (last) begin
         state <= WALK_IDLE;
      end else if (n1 == N1W'(N1_HI)) begin
         n1 <= N1W'(N1_LO);
         n2 <= n2 + 1'b1;
      end else begin
         n1 <= n1 + 1'b1;
      end
   end
endmodule

// File: rtl/pll_divider_search.sv
module pll_divider_search #(
   parameter int FRAC_W    = 16,
   parameter int INT_W     = 8,
   parameter int N1_LO     = 3,
   parameter int N1_HI     = 33,
   parameter int N2_MAX    = 3,
   parameter int M_LO      = 3,
   parameter int M_HI      = 129,
   parameter int DIV_OFS   = 2,
   parameter int N2_POS    = 5,
   parameter int CODE_W    = 8,
   parameter int REJ_SHIFT = 3,
   parameter int DEF_M     = 127,
   parameter int DEF_N1    = 18,
   parameter int DEF_N2    = 2
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic                             start,
   input  logic [INT_W+FRAC_W-1:0]          target_ratio,
   input  logic [INT_W+FRAC_W-1:0]          vco_lo,
   input  logic [INT_W+FRAC_W-1:0]          vco_hi,
   input  logic [$clog2(N2_MAX+1)-1:0]      n2_floor,
   output logic                             done,
   output logic                             found,
   output logic [CODE_W-1:0]                m_code,
   output logic [CODE_W-1:0]                n_code
);
   localparam int TW  = INT_W + FRAC_W;
   localparam int N1W = $clog2(N1_HI + 1);
   localparam int N2W = $clog2(N2_MAX + 1);
   localparam int KW  = N1W + N2_MAX;
   localparam int PW  = TW + KW + 1;
   localparam logic [CODE_W-1:0] DEF_M_CODE = CODE_W'(DEF_M - DIV_OFS);
   localparam logic [CODE_W-1:0] DEF_N_CODE =
      CODE_W'((DEF_N1 - DIV_OFS) + (DEF_N2 << N2_POS));

   // elaboration-time parameter checks
   if (N2_MAX != (1 << N2W) - 1) begin : g_bad_n2
      $error("N2_MAX must fill its field");
   end
   if (M_HI - DIV_OFS >= (1 << CODE_W) || M_HI >= (1 << CODE_W)) begin : g_bad_m
      $error("M range does not fit the code width");
   end
   if (N2_POS + N2W >= CODE_W || N1_HI - DIV_OFS >= (1 << N2_POS)) begin : g_bad_pack
      $error("N field packing does not fit");
   end
   if (FRAC_W < 2 || N1_LO < 1 || N1_LO > N1_HI) begin : g_bad_misc
      $error("bad fraction width or N1 range");
   end

   logic              busy, last, accept, reject, launch;
   logic [TW-1:0]     t_q, lo_q, hi_q;
   logic [N1W-1:0]    n1;
   logic [N2W-1:0]    n2;
   logic              c_ok;
   logic [PW-1:0]     c_err;
   logic [KW-1:0]     c_k;
   logic [CODE_W-1:0] c_m, b_m;
   logic [N1W-1:0]    b_n1;
   logic [N2W-1:0]    b_n2;
   logic [PW-1:0]     t_low, t_high;

   always_comb begin
      t_low  = PW'(target_ratio) << REJ_SHIFT;
      t_high = PW'(target_ratio) << n2_floor;
      accept = start && !busy;
      reject = (t_low < PW'(vco_lo)) || (t_high > PW'(vco_hi));
      launch = accept && !reject;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         t_q  <= '0;
         lo_q <= '0;
         hi_q <= '0;
      end else if (launch) begin
         t_q  <= target_ratio;
         lo_q <= vco_lo;
         hi_q <= vco_hi;
      end
   end

   pll_walk #(
      .N1W(N1W), .N2W(N2W), .N1_LO(N1_LO), .N1_HI(N1_HI), .N2_MAX(N2_MAX)
   ) u_walk (
      .clk(clk), .rst(rst), .launch(launch), .floor_n2(n2_floor),
      .busy(busy), .last(last), .n1(n1), .n2(n2)
   );

   pll_cand_eval #(
      .FRAC_W(FRAC_W), .TW(TW), .N1W(N1W), .N2W(N2W), .KW(KW), .PW(PW),
      .CODE_W(CODE_W), .M_LO(M_LO), .M_HI(M_HI)
   ) u_eval (
      .t(t_q), .lo(lo_q), .hi(hi_q), .n1(n1), .n2(n2),
      .ok(c_ok), .err(c_err), .k(c_k), .m(c_m)
   );

   pll_best_keep #(
      .TW(TW), .KW(KW), .PW(PW), .N1W(N1W), .N2W(N2W), .CODE_W(CODE_W),
      .DEF_M(DEF_M), .DEF_N1(DEF_N1), .DEF_N2(DEF_N2)
   ) u_keep (
      .clk(clk), .rst(rst), .init(launch), .step(busy), .t(target_ratio),
      .cand_ok(c_ok), .cand_err(c_err), .cand_k(c_k), .cand_m(c_m),
      .cand_n1(n1), .cand_n2(n2),
      .nxt_m(b_m), .nxt_n1(b_n1), .nxt_n2(b_n2)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         done   <= 1'b0;
         found  <= 1'b0;
         m_code <= '0;
         n_code <= '0;
      end else begin
         done <= 1'b0;
         if (accept && reject) begin
            done   <= 1'b1;
            found  <= 1'b0;
            m_code <= DEF_M_CODE;
            n_code <= DEF_N_CODE;
         end else if (last) begin
            done   <= 1'b1;
            found  <= 1'b1;
            m_code <= b_m - CODE_W'(DIV_OFS);
            n_code <= CODE_W'(b_n1 - N1W'(DIV_OFS)) | (CODE_W'(b_n2) << N2_POS);
         end
      end
   end
endmodule

// File: rtl/pll_search_checks.sv
module pll_search_checks #(
   parameter int CODE_W  = 8,
   parameter int N2_POS  = 5,
   parameter int N1_LO   = 3,
   parameter int N1_HI   = 33,
   parameter int M_LO    = 3,
   parameter int M_HI    = 129,
   parameter int DIV_OFS = 2,
   parameter int DEF_M   = 127,
   parameter int DEF_N1  = 18,
   parameter int DEF_N2  = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              done,
   input logic              found,
   input logic [CODE_W-1:0] m_code,
   input logic [CODE_W-1:0] n_code
);
   localparam logic [CODE_W-1:0] DM = CODE_W'(DEF_M - DIV_OFS);
   localparam logic [CODE_W-1:0] DN = CODE_W'((DEF_N1 - DIV_OFS) + (DEF_N2 << N2_POS));

   a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   a_r10_hold: assert property (@(posedge clk) disable iff (rst)
      !done |-> ($stable(m_code) && $stable(n_code) && $stable(found)));

   a_r1_reject_default: assert property (@(posedge clk) disable iff (rst)
      (done && !found) |-> (m_code == DM && n_code == DN));

   a_r7_code_shape: assert property (@(posedge clk) disable iff (rst)
      (done && found) |-> (!n_code[CODE_W-1]
         && n_code[N2_POS-1:0] >= N2_POS'(N1_LO - DIV_OFS)
         && n_code[N2_POS-1:0] <= N2_POS'(N1_HI - DIV_OFS)
         && m_code >= CODE_W'(M_LO - DIV_OFS)
         && m_code <= CODE_W'(M_HI - DIV_OFS)));
endmodule

bind pll_divider_search pll_search_checks #(
   .CODE_W(CODE_W), .N2_POS(N2_POS), .N1_LO(N1_LO), .N1_HI(N1_HI),
   .M_LO(M_LO), .M_HI(M_HI), .DIV_OFS(DIV_OFS),
   .DEF_M(DEF_M), .DEF_N1(DEF_N1), .DEF_N2(DEF_N2)
) u_checks (
   .clk(clk), .rst(rst), .done(done), .found(found),
   .m_code(m_code), .n_code(n_code)
);

// File: tb/pll_divider_search_test.sv
module pll_divider_search_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [23:0] target_ratio = '0, vco_lo = '0, vco_hi = '0;
   logic [1:0]  n2_floor = '0;
   logic        done, found;
   logic [7:0]  m_code, n_code;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   pll_divider_search uut (
      .clk(clk), .rst(rst), .start(start), .target_ratio(target_ratio),
      .vco_lo(vco_lo), .vco_hi(vco_hi), .n2_floor(n2_floor),
      .done(done), .found(found), .m_code(m_code), .n_code(n_code)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // exact integer model built from the requirements
   task automatic model(input longint t, input longint lo, input longint hi,
                        input int f, output bit ok, output int mc, output int nc);
      longint ba, bd, k, p, m, a;
      int bm, bn1, bn2;
      if (t * 8 < lo || (t << f) > hi) begin
         ok = 0; mc = 125; nc = 8'h50;
         return;
      end
      ba = t; bd = 1; bm = 127; bn1 = 18; bn2 = 2;
      for (int n2 = f; n2 <= 3; n2++) begin
         for (int n1 = 3; n1 <= 33; n1++) begin
            k = longint'(n1) << n2;
            p = t * k;
            m = (p + 32768) >>> 16;
            if (m < 3 || m > 129) continue;
            if ((m << 16) < lo * n1 || (m << 16) > hi * n1) continue;
            a = (p >= (m << 16)) ? p - (m << 16) : (m << 16) - p;
            if (a * bd < ba * k) begin
               ba = a; bd = k; bm = int'(m); bn1 = n1; bn2 = n2;
            end
         end
      end
      ok = 1; mc = bm - 2; nc = (bn1 - 2) | (bn2 << 5);
   endtask

   task automatic run_job(input longint t, input longint lo, input longint hi,
                          input int f, input bit ghost, input string tag);
      bit eok; int emc, enc, cnt, elat;
      logic [7:0] hm, hn;
      model(t, lo, hi, f, eok, emc, enc);
      elat = eok ? (4 - f) * 31 + 1 : 1;
      @(negedge clk);
      target_ratio = 24'(t); vco_lo = 24'(lo); vco_hi = 24'(hi); n2_floor = 2'(f);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cnt = 1;
      while (done !== 1'b1 && cnt < 400) begin
         if (ghost && cnt == 5) begin
            start = 1'b1; target_ratio = 24'h0FFFFF; n2_floor = 2'd3;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         cnt++;
      end
      start = 1'b0;
      chk({tag, " R8 latency"}, cnt, elat);
      chk({tag, " R1 R6 found"}, found, eok);
      chk({tag, " R2 R3 R4 R5 R7 m_code"}, m_code, emc);
      chk({tag, " R2 R3 R4 R5 R7 n_code"}, n_code, enc);
      hm = m_code; hn = n_code;
      @(negedge clk);
      chk({tag, " R10 done single"}, done, 0);
      chk({tag, " R10 hold m"}, m_code, hm);
      chk({tag, " R10 hold n"}, n_code, hn);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      longint lo, hi, tl, th, t;
      int f;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R11 reset done", done, 0);
      chk("R11 reset found", found, 0);
      chk("R11 reset m_code", m_code, 0);
      chk("R11 reset n_code", n_code, 0);

      run_job(115232, 457716, 1144290, 0, 0, "typical");
      run_job(57214, 457720, 1144290, 0, 0, "R1 below low bound");
      run_job(57215, 457720, 1144290, 0, 0, "R1 on low bound");
      run_job(286073, 457716, 1144290, 2, 0, "R1 above high bound");
      run_job(286072, 457716, 1144290, 2, 0, "R1 on high bound");
      run_job(100000, 457716, 1144290, 3, 0, "floor3");
      run_job(125001, 1000008, 1000008, 3, 0, "R6 no candidate");
      chk("R6 default m literal", m_code, 8'h7D);
      chk("R6 default n literal", n_code, 8'h50);
      run_job(115232, 457716, 1144290, 1, 1, "R9 ghost start");

      for (int i = 0; i < 40; i++) begin
         lo = 300000 + longint'($urandom % 400000);
         hi = lo + longint'($urandom % 900000);
         f  = int'($urandom % 4);
         tl = (lo + 7) >>> 3;
         th = hi >>> f;
         if (th >= tl && ($urandom % 8) != 0)
            t = tl + longint'($urandom % 32'(th - tl + 1));
         else if ($urandom % 2 == 0)
            t = th + 1 + longint'($urandom % 1000);
         else
            t = (tl > 1000) ? tl - 1 - longint'($urandom % 1000) : 1;
         run_job(t, lo, hi, f, (i % 7) == 3, "random");
      end

      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule